// File: doc/BRIEF.md
# Selectable Clock Divider with Phase Slip

This block derives a slower sample clock from a fast input clock, dividing by one, two or four. A 3-bit divisor control register can force the divisor. It can also hand the choice to an external three-state strap, which reaches the block already decoded into a 2-bit code. The divided clock is given as two signals. `divEn` is a one-cycle enable on each divided rising edge. `divClk` is the level of the divided clock.

Several converters fed from one fast clock can end up with divided phases that do not match. To line them up, software writes a slip bit through a small register write port. Each 0-to-1 transition of that bit pulls the next divided rising edge one input cycle earlier, and it does so only when dividing by four. The block pulses `slipDone` for one cycle when a slip takes effect.

A soft reset re-phases the divider and clears the slip bit. It leaves the divisor control register untouched. Only the asynchronous power-on reset clears that register.

Top module: `clkdiv_slip`

## Requirements
- R1: Divisor register codes 3'b001, 3'b010 and 3'b100 select division by 1, 2 and 4. The interval between `divEn` pulses is then 1, 2 or 4 input cycles.
- R2: Register code 3'b000, and any code other than the three in R1, hands the choice to `pinMode`. In that case 2'b00 divides by 1, 2'b01 by 2, 2'b10 by 4, and the unused code 2'b11 divides by 1.
- R3: `porRstN` low clears the divisor register to 3'b000. During that reset `divEn` and `divClk` are high and `slipDone` is low. A `softRst` pulse restarts the divider phase, so `divEn` is high in the cycle after the edge that samples it, and it keeps the divisor register value.
- R4: `divClk` is high for the first half of each divided period, starting with the `divEn` cycle: 2 of 4 cycles, 1 of 2 cycles, and always high when dividing by 1.
- R5: In divide-by-4, a slip shortens exactly one `divEn` interval to 3 cycles, and the following intervals are 4 cycles again. If the request arrives when a rising edge is already due on the next cycle, the interval after that edge is the one shortened.
- R6: A slip is triggered only by a write of 1 to bit 0 of the slip register (write address 1) while that bit holds 0. Writing 1 again without first writing 0 has no effect.
- R7: Two slip commands advance the divided phase by two input cycles in total.
- R8: In divide-by-1 and divide-by-2, slip commands are ignored: the `divEn` phase is unchanged and `slipDone` stays low.
- R9: Any change of the effective divisor restarts the counter at zero. `divEn` is then high in the second cycle after the register write is sampled.
- R10: `slipDone` pulses once for each slip applied, in the first cycle of the shortened phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| porRstN | input | 1 | Asynchronous power-on/hard reset, active low |
| softRst | input | 1 | Synchronous soft reset; keeps the divisor register |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = divisor control register, 1 = slip register |
| wrData | input | 3 | Write data; bits [2:0] for the divisor code, bit 0 for the slip bit |
| pinMode | input | 2 | Decoded external divisor strap code |
| divEn | output | 1 | One-cycle enable on each divided rising edge |
| divClk | output | 1 | Divided clock level |
| slipDone | output | 1 | One-cycle strobe when a slip is applied |

## Verification
The hardest case to reach is a slip request that lands while the counter sits on its last count. There the edge is already due on the next cycle, so the advance has to be held over and applied one cycle later. The bench reaches this case by timing alone. It aligns on a `divEn` pulse, then issues the write of 0 and the write of 1 back to back, so the write of 1 is sampled exactly on the fourth phase. It then checks that the next interval is 3 cycles. The double-slip test uses the same alignment and checks the phase modulo four against a free-running cycle count.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CTRL_W  = 3;
  localparam int PIN_W   = 2;
  localparam int MAX_DIV = 4;
  localparam int CNT_W   = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    DIV_1 = 2'd0,
    DIV_2 = 2'd1,
    DIV_4 = 2'd2
  } divSel_e;

  typedef struct packed {
    logic restart;
    logic slip;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic [PIN_W-1:0]  pinMode,
  output divSel_e           modeQ,
  output ctrlStrobe_t       strobe
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              slipBitQ;
  divSel_e           effSel;
  divSel_e           pinSel;
  logic              slipRise;

  always_comb begin
    case (pinMode)
      2'b01:   pinSel = DIV_2;
      2'b10:   pinSel = DIV_4;
      default: pinSel = DIV_1;
    endcase
    case (ctrlReg)
      3'b001:  effSel = DIV_1;
      3'b010:  effSel = DIV_2;
      3'b100:  effSel = DIV_4;
      default: effSel = pinSel;
    endcase
  end

  // divisor register survives soft reset
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                ctrlReg <= '0;
    else if (wrEn && !wrAddr)    ctrlReg <= wrData;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                slipBitQ <= 1'b0;
    else if (softRst)            slipBitQ <= 1'b0;
    else if (wrEn && wrAddr)     slipBitQ <= wrData[0];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) modeQ <= DIV_1;
    else          modeQ <= effSel;
  end

  assign slipRise       = wrEn && wrAddr && wrData[0] && !slipBitQ && !softRst;
  assign strobe.restart = (effSel != modeQ);
  assign strobe.slip    = slipRise && (modeQ == DIV_4) && !strobe.restart;

  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!porRstN)
    !(wrEn && !wrAddr) |=> $stable(ctrlReg));

  p_slip_rise_r6: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.slip |=> slipBitQ);
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        porRstN,
  input  logic        softRst,
  input  divSel_e     mode,
  input  ctrlStrobe_t strobe,
  output logic        divEn,
  output logic        divClk,
  output logic        slipDone
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wrapVal;
  logic             pend;
  logic             doSlip;

  always_comb begin
    case (mode)
      DIV_2:   wrapVal = CNT_W'(1);
      DIV_4:   wrapVal = CNT_W'(3);
      default: wrapVal = '0;
    endcase
  end

  // a slip due on the last count is held over one cycle
  assign doSlip = (pend || strobe.slip) && (cnt != wrapVal);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cnt      <= '0;
      pend     <= 1'b0;
      slipDone <= 1'b0;
    end else if (softRst || strobe.restart) begin
      cnt      <= '0;
      pend     <= 1'b0;
      slipDone <= 1'b0;
    end else if (doSlip) begin
      cnt      <= cnt + CNT_W'(2);
      pend     <= 1'b0;
      slipDone <= 1'b1;
    end else begin
      cnt      <= (cnt == wrapVal) ? '0 : cnt + CNT_W'(1);
      pend     <= pend || strobe.slip;
      slipDone <= 1'b0;
    end
  end

  assign divEn = (cnt == '0);

  always_comb begin
    case (mode)
      DIV_2:   divClk = (cnt[0] == 1'b0);
      DIV_4:   divClk = (cnt < CNT_W'(2));
      default: divClk = 1'b1;
    endcase
  end

  p_slip_only_div4_r8: assert property (@(posedge clk) disable iff (!porRstN)
    slipDone |-> mode == DIV_4);

  p_pend_div4_r5: assert property (@(posedge clk) disable iff (!porRstN)
    pend |-> mode == DIV_4);

  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.restart |=> (cnt == '0) && !slipDone);

  p_div1_still_r1: assert property (@(posedge clk) disable iff (!porRstN)
    (mode == DIV_1) |-> (cnt == '0));

  p_div2_range_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (mode == DIV_2) |-> (cnt <= CNT_W'(1)));
endmodule

// File: rtl/clkdiv_slip.sv
module clkdiv_slip
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRst,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic [PIN_W-1:0]  pinMode,
  output logic              divEn,
  output logic              divClk,
  output logic              slipDone
);
  divSel_e     modeQ;
  ctrlStrobe_t strobe;

  clkdiv_ctrl ctrl_i (
    .clk     (clk),
    .porRstN (porRstN),
    .softRst (softRst),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .pinMode (pinMode),
    .modeQ   (modeQ),
    .strobe  (strobe)
  );

  clkdiv_dp dp_i (
    .clk      (clk),
    .porRstN  (porRstN),
    .softRst  (softRst),
    .mode     (modeQ),
    .strobe   (strobe),
    .divEn    (divEn),
    .divClk   (divClk),
    .slipDone (slipDone)
  );
endmodule

// File: tb/clkdiv_slip_tb_top.sv
module clkdiv_slip_tb_top;
  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       softRst = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [2:0] wrData = '0;
  logic [1:0] pinMode = '0;
  logic       divEn, divClk, slipDone;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int doneCnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  clkdiv_slip dut_i (
    .clk(clk), .porRstN(porRstN), .softRst(softRst), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pinMode(pinMode),
    .divEn(divEn), .divClk(divClk), .slipDone(slipDone)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (porRstN && slipDone) doneCnt <= doneCnt + 1;

  // [7:5] register code, [4:3] pin code, [2:0] expected interval
  localparam logic [7:0] VEC [11] = '{
    {3'b001, 2'b10, 3'd1}, {3'b010, 2'b00, 3'd2}, {3'b100, 2'b00, 3'd4},
    {3'b000, 2'b00, 3'd1}, {3'b000, 2'b01, 3'd2}, {3'b000, 2'b10, 3'd4},
    {3'b000, 2'b11, 3'd1}, {3'b011, 2'b10, 3'd4}, {3'b111, 2'b01, 3'd2},
    {3'b101, 2'b00, 3'd1}, {3'b110, 2'b10, 3'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [2:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic alignEn();
    do @(negedge clk); while (!divEn);
  endtask

  task automatic measure(output int ivl, output int hi, output int dn);
    while (!divEn) @(negedge clk);
    ivl = 0; hi = 0; dn = 0;
    do begin
      if (divClk) hi++;
      if (slipDone) dn++;
      @(negedge clk);
      ivl++;
    end while (!divEn);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int ivl, hi, dn, t0, d0;
    repeat (3) @(negedge clk);
    // R3: state during power-on reset
    chk("R3 divEn in reset", int'(divEn), 1);
    chk("R3 divClk in reset", int'(divClk), 1);
    chk("R3 slipDone in reset", int'(slipDone), 0);
    porRstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1/R2/R4 table walk
    for (int i = 0; i < 11; i++) begin
      pinMode = VEC[i][4:3];
      wr(1'b0, VEC[i][7:5]);
      repeat (6) @(negedge clk);
      measure(ivl, hi, dn);
      chk((VEC[i][7:5] inside {3'b001, 3'b010, 3'b100}) ? "R1 interval" : "R2 interval",
          ivl, int'(VEC[i][2:0]));
      measure(ivl, hi, dn);
      chk("R4 divClk high cycles", hi, (VEC[i][2:0] == 3'd1) ? 1 : int'(VEC[i][2:0]) / 2);
    end

    // R5 and R10: slip landing on the last count, held one cycle
    pinMode = 2'b00;
    wr(1'b0, 3'b100);
    repeat (6) @(negedge clk);
    alignEn();
    wr(1'b1, 3'b000);
    wr(1'b1, 3'b001);
    chk("R5 divEn at held slip", int'(divEn), 1);
    measure(ivl, hi, dn);
    chk("R5 shortened interval", ivl, 3);
    chk("R10 slipDone pulses", dn, 1);
    measure(ivl, hi, dn);
    chk("R5 interval after slip", ivl, 4);

    // R6: second write of 1 without a 0
    d0 = doneCnt;
    wr(1'b1, 3'b001);
    repeat (8) @(negedge clk);
    chk("R6 no slip strobe", doneCnt - d0, 0);
    measure(ivl, hi, dn);
    chk("R6 interval unchanged", ivl, 4);

    // R7: two slips
    alignEn();
    t0 = cyc; d0 = doneCnt;
    wr(1'b1, 3'b000); wr(1'b1, 3'b001);
    wr(1'b1, 3'b000); wr(1'b1, 3'b001);
    repeat (12) @(negedge clk);
    alignEn();
    chk("R7 phase advanced by two", (cyc - t0) % 4, 2);
    chk("R10 two strobes", doneCnt - d0, 2);

    // R8: ignored in divide-by-2 and divide-by-1
    wr(1'b0, 3'b010);
    wr(1'b1, 3'b000);
    repeat (4) @(negedge clk);
    alignEn();
    t0 = cyc; d0 = doneCnt;
    wr(1'b1, 3'b001);
    repeat (6) @(negedge clk);
    alignEn();
    chk("R8 div2 phase kept", (cyc - t0) % 2, 0);
    chk("R8 div2 no strobe", doneCnt - d0, 0);
    measure(ivl, hi, dn);
    chk("R8 div2 interval", ivl, 2);
    wr(1'b0, 3'b001);
    wr(1'b1, 3'b000);
    d0 = doneCnt;
    wr(1'b1, 3'b001);
    repeat (6) @(negedge clk);
    chk("R8 div1 no strobe", doneCnt - d0, 0);
    measure(ivl, hi, dn);
    chk("R8 div1 interval", ivl, 1);

    // R9: divisor change restarts at zero (div4 -> div2 mid-period)
    wr(1'b0, 3'b100);
    repeat (6) @(negedge clk);
    alignEn();
    wr(1'b0, 3'b010);
    @(negedge clk);
    chk("R9 divEn after restart", int'(divEn), 1);
    chk("R9 divClk after restart", int'(divClk), 1);
    @(negedge clk);
    chk("R9 low phase of div2", int'(divEn), 0);
    @(negedge clk);
    chk("R9 next div2 edge", int'(divEn), 1);

    // R3: soft reset keeps divisor register, re-phases
    wr(1'b0, 3'b100);
    pinMode = 2'b00;
    repeat (6) @(negedge clk);
    alignEn();
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    chk("R3 soft reset re-phase", int'(divEn), 1);
    measure(ivl, hi, dn);
    chk("R3 divisor kept over soft reset", ivl, 4);

    // R3: hard reset clears divisor register
    @(negedge clk); porRstN = 1'b0;
    repeat (2) @(negedge clk); porRstN = 1'b1;
    repeat (4) @(negedge clk);
    measure(ivl, hi, dn);
    chk("R3 hard reset clears register", ivl, 1);

    summary();
  end
endmodule